// File: doc/BRIEF.md
# Strobed Slot Receiver and Trigger Evaluator

This block receives a short pattern that an upstream board sends over a narrow link, a few bits at a time, on the fast clock. Each cycle it samples a bank of one-hot slot strobes and a group of data lines. The active strobe selects which slice of an internal pattern buffer the data lines fill. When the last slot arrives, the block raises a frame-complete flag. In the cycle after that flag it evaluates two trigger conditions on the rebuilt pattern, presents the whole pattern with a one-cycle valid, and clears the buffer so the next frame starts empty.

If a cycle has no strobe high, the link is idle and nothing is stored. If a cycle has more than one strobe high, the strobe pattern is corrupt: nothing is stored and a saturating error counter increases. The default build has three slots of three bits, which gives a nine-bit pattern. Decision A reports the lowest pattern bit. Decision B reports the lowest and highest pattern bits together.

Top module: `slot_rx_eval`

## Requirements
- R1: While reset is held and on its release, frame_done_o, dec_a_o, dec_b_o, word_valid_o, word_o and err_count_o are all zero.
- R2: A cycle with only strobe_i[0] high stores data_i[k] into pattern bit k, for k = 0..2.
- R3: A cycle with only strobe_i[1] high stores data_i[k] into pattern bit 3+k.
- R4: A cycle with only strobe_i[2] high stores data_i[k] into pattern bit 6+k, and frame_done_o is high in the following cycle.
- R5: In the cycle after frame_done_o is high, word_valid_o is high and word_o equals the assembled pattern, including the last slot. word_o holds its value until the next evaluation.
- R6: dec_a_o is high in the evaluation cycle exactly when pattern bit 0 is set.
- R7: dec_b_o is high in the evaluation cycle exactly when pattern bits 0 and 8 are both set.
- R8: The evaluation clears the whole pattern buffer. In the next frame, a slot that is not rewritten reads as zero.
- R9: dec_a_o, dec_b_o and word_valid_o are one-cycle pulses. They drop in the next cycle unless another frame completed.
- R10: A cycle with two or more strobes high stores nothing and increments err_count_o, which saturates at its all-ones value.
- R11: A cycle with no strobe high stores nothing and leaves err_count_o unchanged.
- R12: A one-hot strobe that arrives in the evaluation cycle is stored into the freshly cleared buffer and is not lost.
- R13: Writing the same slot twice within one frame keeps the later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | NUM_SLOTS | One-hot slot select; bit s addresses slot s |
| data_i | input | SLOT_W | Slot data lines |
| frame_done_o | output | 1 | High for the cycle after the last slot was stored |
| dec_a_o | output | 1 | Decision pulse: pattern bit 0 set |
| dec_b_o | output | 1 | Decision pulse: pattern bits 0 and top both set |
| word_o | output | SLOT_W*NUM_SLOTS | Assembled pattern from the last evaluation |
| word_valid_o | output | 1 | One-cycle valid for word_o |
| err_count_o | output | ERR_W | Saturating count of multi-strobe cycles |

## Verification
The latencies are counted in rising edges from the edge that samples a strobe. A stored slot and err_count_o change at that edge. frame_done_o rises at that edge for the last slot. The decisions, word_valid_o and word_o change one edge later. The bench sets strobes and data at the falling edge. It steps a reference model once per rising edge and compares every output at the next falling edge, so each result is read in the cycle its latency puts it in. The directed frames then check the slice positions, the clearing and the pulse widths at fixed steps after the third slot.

// File: rtl/slot_rx_pkg.sv
package slot_rx_pkg;

  typedef enum logic [1:0] {
    STB_IDLE  = 2'd0,
    STB_ONE   = 2'd1,
    STB_MULTI = 2'd2
  } stb_kind_t;

endpackage

// File: rtl/slot_rx_rst_sync.sv
module slot_rx_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/slot_rx_strobe_check.sv
module slot_rx_strobe_check
  import slot_rx_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int ERR_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] strobe_i,
  output logic [NUM_SLOTS-1:0] wr_en_o,
  output logic [ERR_W-1:0]     err_count_o
);

  localparam int CNT_W = $clog2(NUM_SLOTS + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [CNT_W-1:0] hot_cnt;
  stb_kind_t        kind;
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_n;
  logic             err_en;

  // classify the strobe bank
  always_comb begin
    hot_cnt = CNT_W'($countones(strobe_i));
    if (hot_cnt == '0)
      kind = STB_IDLE;
    else if (hot_cnt == CNT_W'(1))
      kind = STB_ONE;
    else
      kind = STB_MULTI;
    wr_en_o = (kind == STB_ONE) ? strobe_i : '0;
  end

  // error counter next state with explicit enable
  always_comb begin
    err_en = (kind == STB_MULTI) && (err_q != ERR_MAX);
    err_n  = err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= '0;
    else if (err_en)
      err_q <= err_n;
  end

  assign err_count_o = err_q;

  // R10
  multi_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(strobe_i) > 1 && err_count_o != ERR_MAX) |=>
      err_count_o == ERR_W'($past(err_count_o) + 1'b1));

  // R10
  err_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count_o == ERR_MAX) |=> err_count_o == ERR_MAX);

  // R11
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i == '0) |=> $stable(err_count_o));

endmodule

// File: rtl/slot_rx_slot_buffer.sv
module slot_rx_slot_buffer #(
  parameter int SLOT_W    = 3,
  parameter int NUM_SLOTS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        wr_en_i,
  input  logic                        clr_i,
  input  logic [SLOT_W-1:0]           data_i,
  output logic [SLOT_W*NUM_SLOTS-1:0] pat_o
);

  localparam int WORD_W = SLOT_W * NUM_SLOTS;

  logic [WORD_W-1:0] pat_q;
  logic [WORD_W-1:0] pat_n;

  // one slice per slot: a write beats the clear
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      if (wr_en_i[s])
        pat_n[s*SLOT_W +: SLOT_W] = data_i;
      else if (clr_i)
        pat_n[s*SLOT_W +: SLOT_W] = '0;
      else
        pat_n[s*SLOT_W +: SLOT_W] = pat_q[s*SLOT_W +: SLOT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pat_q <= '0;
    else
      pat_q <= pat_n;
  end

  assign pat_o = pat_q;

  // R10
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && wr_en_i == '0) |=> $stable(pat_o));

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && wr_en_i == '0) |=> pat_o == '0);

endmodule

// File: rtl/slot_rx_frame_eval.sv
module slot_rx_frame_eval #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_last_i,
  input  logic [WORD_W-1:0] pat_i,
  output logic              frame_done_o,
  output logic              dec_a_o,
  output logic              dec_b_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  logic              done_q, done_n;
  logic              dec_a_q, dec_a_n;
  logic              dec_b_q, dec_b_n;
  logic              valid_q, valid_n;
  logic [WORD_W-1:0] word_q;
  logic              word_en;

  always_comb begin
    done_n  = wr_last_i;
    word_en = done_q;
    if (done_q) begin
      valid_n = 1'b1;
      dec_a_n = pat_i[0];
      dec_b_n = pat_i[0] & pat_i[WORD_W-1];
    end else begin
      valid_n = 1'b0;
      dec_a_n = 1'b0;
      dec_b_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      dec_a_q <= 1'b0;
      dec_b_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      done_q  <= done_n;
      dec_a_q <= dec_a_n;
      dec_b_q <= dec_b_n;
      valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= '0;
    else if (word_en)
      word_q <= pat_i;
  end

  assign frame_done_o = done_q;
  assign dec_a_o      = dec_a_q;
  assign dec_b_o      = dec_b_q;
  assign word_o       = word_q;
  assign word_valid_o = valid_q;

  // R4
  last_slot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last_i |=> frame_done_o);

  // R5
  eval_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> (word_valid_o && word_o == $past(pat_i)));

  // R6
  dec_a_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (dec_a_o == word_o[0]));

  // R7
  dec_b_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (dec_b_o == (word_o[0] && word_o[WORD_W-1])));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !frame_done_o) |=> (!word_valid_o && !dec_a_o && !dec_b_o));

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_o |=> $stable(word_o));

endmodule

// File: rtl/slot_rx_eval.sv
module slot_rx_eval
  import slot_rx_pkg::*;
#(
  parameter int SLOT_W    = 3,
  parameter int NUM_SLOTS = 3,
  parameter int ERR_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        strobe_i,
  input  logic [SLOT_W-1:0]           data_i,
  output logic                        frame_done_o,
  output logic                        dec_a_o,
  output logic                        dec_b_o,
  output logic [SLOT_W*NUM_SLOTS-1:0] word_o,
  output logic                        word_valid_o,
  output logic [ERR_W-1:0]            err_count_o
);

  localparam int WORD_W = SLOT_W * NUM_SLOTS;

  logic                 rst_n_sync;
  logic [NUM_SLOTS-1:0] wr_en;
  logic [WORD_W-1:0]    pat;
  logic                 frame_done;

  slot_rx_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  slot_rx_strobe_check #(
    .NUM_SLOTS (NUM_SLOTS),
    .ERR_W     (ERR_W)
  ) u_stb (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .strobe_i    (strobe_i),
    .wr_en_o     (wr_en),
    .err_count_o (err_count_o)
  );

  slot_rx_slot_buffer #(
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en_i (wr_en),
    .clr_i   (frame_done),
    .data_i  (data_i),
    .pat_o   (pat)
  );

  slot_rx_frame_eval #(
    .WORD_W (WORD_W)
  ) u_eval (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .wr_last_i    (wr_en[NUM_SLOTS-1]),
    .pat_i        (pat),
    .frame_done_o (frame_done),
    .dec_a_o      (dec_a_o),
    .dec_b_o      (dec_b_o),
    .word_o       (word_o),
    .word_valid_o (word_valid_o)
  );

  assign frame_done_o = frame_done;

endmodule

// File: tb/slot_rx_eval_tb_top.sv
module slot_rx_eval_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 24681;

  logic       clk;
  logic       rst_n;
  logic [2:0] strobe;
  logic [2:0] data;
  logic       frame_done, dec_a, dec_b, word_valid;
  logic [8:0] word;
  logic [3:0] err_count;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state
  logic [8:0] m_pat;
  logic       m_done, m_dec_a, m_dec_b, m_valid;
  logic [8:0] m_word;
  logic [3:0] m_err;

  slot_rx_eval dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_i     (strobe),
    .data_i       (data),
    .frame_done_o (frame_done),
    .dec_a_o      (dec_a),
    .dec_b_o      (dec_b),
    .word_o       (word),
    .word_valid_o (word_valid),
    .err_count_o  (err_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int hot(input logic [2:0] s);
    return int'(s[0]) + int'(s[1]) + int'(s[2]);
  endfunction

  // one rising edge of the reference behaviour
  task automatic model_edge(input logic [2:0] s, input logic [2:0] d);
    logic [8:0] n_pat;
    n_pat     = m_done ? 9'd0 : m_pat;
    m_valid   = m_done;
    m_dec_a   = m_done ? m_pat[0] : 1'b0;
    m_dec_b   = m_done ? (m_pat[0] & m_pat[8]) : 1'b0;
    if (m_done) m_word = m_pat;
    if (hot(s) == 1) begin
      if (s[0]) n_pat[2:0] = d;
      if (s[1]) n_pat[5:3] = d;
      if (s[2]) n_pat[8:6] = d;
    end
    if (hot(s) > 1 && m_err != 4'hF) m_err = m_err + 4'd1;
    m_done = (hot(s) == 1) && s[2];
    m_pat  = n_pat;
  endtask

  task automatic compare_all();
    chk("R4 frame_done", 32'(frame_done), 32'(m_done));
    chk("R5 word_valid", 32'(word_valid), 32'(m_valid));
    chk("R5 word", 32'(word), 32'(m_word));
    chk("R6 dec_a", 32'(dec_a), 32'(m_dec_a));
    chk("R7 dec_b", 32'(dec_b), 32'(m_dec_b));
    chk("R10 err_count", 32'(err_count), 32'(m_err));
  endtask

  task automatic step(input logic [2:0] s, input logic [2:0] d);
    strobe = s;
    data   = d;
    @(posedge clk);
    model_edge(s, d);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(SEED));
    rst_n   = 1'b0;
    strobe  = 3'b000;
    data    = 3'b000;
    m_pat   = '0; m_done = 0; m_dec_a = 0; m_dec_b = 0;
    m_valid = 0;  m_word = '0; m_err = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 outputs in reset", {22'd0, frame_done, dec_a, dec_b, word_valid, word, err_count}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs after release", {22'd0, frame_done, dec_a, dec_b, word_valid, word, err_count}, 32'd0);

    // full frame, both decisions true
    step(3'b001, 3'b101);
    step(3'b010, 3'b011);
    step(3'b100, 3'b110);
    chk("R4 done after last slot", 32'(frame_done), 32'd1);
    step(3'b000, 3'b000);
    chk("R2 slot0 bits", 32'(word[2:0]), 32'h5);
    chk("R3 slot1 bits", 32'(word[5:3]), 32'h3);
    chk("R4 slot2 bits", 32'(word[8:6]), 32'h6);
    chk("R5 valid in eval cycle", 32'(word_valid), 32'd1);
    chk("R6 dec_a set", 32'(dec_a), 32'd1);
    chk("R7 dec_b set", 32'(dec_b), 32'd1);
    step(3'b000, 3'b000);
    chk("R9 dec_a dropped", 32'(dec_a), 32'd0);
    chk("R9 valid dropped", 32'(word_valid), 32'd0);

    // slot0 skipped: cleared buffer must read zero
    step(3'b010, 3'b000);
    step(3'b100, 3'b011);
    step(3'b000, 3'b000);
    chk("R8 unwritten slot cleared", 32'(word[2:0]), 32'd0);
    chk("R6 dec_a clear", 32'(dec_a), 32'd0);
    chk("R7 dec_b clear", 32'(dec_b), 32'd0);

    // overwrite and idle-with-data
    step(3'b001, 3'b111);
    step(3'b000, 3'b111);
    step(3'b001, 3'b001);
    step(3'b100, 3'b000);
    step(3'b000, 3'b000);
    chk("R13 later write kept", 32'(word[2:0]), 32'h1);
    chk("R11 idle stores nothing", 32'(word[5:3]), 32'd0);
    chk("R7 dec_b needs top bit", 32'(dec_b), 32'd0);
    chk("R11 idle no error", 32'(err_count), 32'd0);

    // strobe in the evaluation cycle
    step(3'b001, 3'b011);
    step(3'b010, 3'b001);
    step(3'b100, 3'b100);
    step(3'b001, 3'b110);
    chk("R5 word before new slot", 32'(word), 32'h10B);
    step(3'b010, 3'b000);
    step(3'b100, 3'b000);
    step(3'b000, 3'b000);
    chk("R12 eval-cycle slot kept", 32'(word[2:0]), 32'h6);

    // multi-strobe: no store, count
    step(3'b001, 3'b000);
    step(3'b011, 3'b111);
    chk("R10 count one", 32'(err_count), 32'd1);
    step(3'b010, 3'b000);
    step(3'b100, 3'b000);
    step(3'b000, 3'b000);
    chk("R10 multi stored nothing", 32'(word), 32'd0);
    for (int i = 0; i < 20; i++) step(3'b111, 3'(i));
    chk("R10 saturated", 32'(err_count), 32'hF);

    // constrained random traffic
    begin
      int nxt = 0;
      for (int i = 0; i < 600; i++) begin
        int r = int'($urandom % 10);
        logic [2:0] s;
        if (r < 7) begin
          s = 3'b001 << nxt;
          nxt = (nxt + 1) % 3;
        end else if (r == 7) begin
          s = 3'b000;
        end else if (r == 8) begin
          case ($urandom % 4)
            0: s = 3'b011;
            1: s = 3'b101;
            2: s = 3'b110;
            default: s = 3'b111;
          endcase
        end else begin
          s = 3'($urandom);
        end
        step(s, 3'($urandom));
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule